// File: doc/BRIEF.md
# Stereo Voice Mixer and Output Stage

This block forms one stereo output sample per tick of a sample strobe. Every voice's mono sample is scaled by its own left and right volume, and the results are summed into two accumulators. The main sum feeds the speakers. The send sum, which holds only the voices picked by a per-voice mask, feeds an external reverb engine. An external disc-audio stereo input can then be added to either sum under separate enables. A mix-enable input can silence all voice contributions.

The send sum is saturated and driven out to the reverb engine. The reverb engine's return is scaled and added to the main sum. The main sum is then saturated, scaled by a master volume, saturated again, and reduced to 75 % to leave headroom for later resampling. A 9-bit capture address advances once per sample so a downstream capture buffer can be indexed. All results are registered on the strobe edge, and a one-cycle valid pulse follows.

Top module: `stereo_mix_out`

## Requirements
- R1: On a strobe, each voice adds floor(sample * volume / 2^15) to the main left sum using its left volume, and the same term using its right volume to the main right sum. Samples and volumes are signed 16-bit. Voice v occupies bits [16v+15:16v] of the packed inputs.
- R2: A voice's two scaled terms go into the send sums only when bit v of `rvb_mask` is 1.
- R3: When `mix_en` is 0, both voice sums (main and send) are cleared before the disc-audio term is added.
- R4: The disc-audio term is floor(cd * cd_vol / 2^15) per channel. It is added to the main sum only when `cd_en` is 1.
- R5: The disc-audio term is added to the send sum only when `cd_en` and `cd_rvb` are both 1.
- R6: `send_l`/`send_r` carry the send sums clamped to [-32768, 32767].
- R7: floor(rvb_ret * rvb_vol / 2^15) is added to the main sum, and the result is clamped to 16 bits.
- R8: The clamped main sum is multiplied by the master volume, shifted right by 15 with floor, and clamped to 16 bits again.
- R9: Each output channel equals floor((x*3 + 2) / 4), where x is the R8 result. The output therefore stays within [-24576, 24575].
- R10: `cap_addr` is 0 after reset. It increments by one on every strobe and wraps from 511 to 0.
- R11: After reset all outputs are 0. Results are loaded on the clock edge that samples `sample_stb` high, and `out_valid` is high for the following cycle only. Without a strobe, the data outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle sample tick |
| voice_smp | input | NUM_VOICES*16 | Packed signed voice samples |
| voice_vol_l | input | NUM_VOICES*16 | Packed signed left volumes |
| voice_vol_r | input | NUM_VOICES*16 | Packed signed right volumes |
| rvb_mask | input | NUM_VOICES | Per-voice reverb send select |
| mix_en | input | 1 | 0 silences all voices |
| cd_en | input | 1 | Adds disc audio to the main sum |
| cd_rvb | input | 1 | Also feeds disc audio to the send (needs cd_en) |
| cd_l | input | 16 | Disc audio left sample |
| cd_r | input | 16 | Disc audio right sample |
| cd_vol_l | input | 16 | Disc audio left volume |
| cd_vol_r | input | 16 | Disc audio right volume |
| rvb_ret_l | input | 16 | Reverb return left |
| rvb_ret_r | input | 16 | Reverb return right |
| rvb_vol_l | input | 16 | Reverb return left volume |
| rvb_vol_r | input | 16 | Reverb return right volume |
| mst_vol_l | input | 16 | Master left volume |
| mst_vol_r | input | 16 | Master right volume |
| out_l | output | 16 | Final left sample |
| out_r | output | 16 | Final right sample |
| out_valid | output | 1 | Pulses one cycle after a strobe |
| send_l | output | 16 | Saturated reverb send left |
| send_r | output | 16 | Saturated reverb send right |
| cap_addr | output | 9 | Capture write address |

## Verification
The block's only state is the output registers and the capture counter, so an internal fault appears at the ports in the first valid cycle after the strobe that exercises it. A wrong mask, gate or enable decode shows in that same sample's send or output values. A missing clamp shows only when sums are driven to full scale, so the stimulus includes all-voices-at-maximum and negative-times-negative master products. A counter fault shows in `cap_addr` on the next sample, and the wrap across 511 is covered.

// File: rtl/stereo_mix_pkg.sv
package stereo_mix_pkg;

    localparam int SMP_W = 16;
    localparam int ACC_W = 32;
    localparam int VOL_SHIFT = 15;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t l;
        acc_t r;
    } acc_pair_t;

    typedef struct packed {
        smp_t l;
        smp_t r;
    } smp_pair_t;

    // signed multiply with floor shift by the volume scale
    function automatic acc_t vol_scale(smp_t s, smp_t v);
        acc_t p;
        p = acc_t'(s) * acc_t'(v);
        return p >>> VOL_SHIFT;
    endfunction

    function automatic smp_t sat16(acc_t x);
        if (x > acc_t'(32767))
            return smp_t'(16'sh7fff);
        else if (x < acc_t'(-32768))
            return smp_t'(-16'sh8000);
        else
            return smp_t'(x[SMP_W-1:0]);
    endfunction

    // three-quarter scale with rounding offset
    function automatic smp_t headroom(smp_t x);
        acc_t t;
        t = acc_t'(x) * acc_t'(3) + acc_t'(2);
        t = t >>> 2;
        return smp_t'(t[SMP_W-1:0]);
    endfunction

    function automatic smp_t final_chan(acc_t m, smp_t ret, smp_t rv, smp_t mv);
        smp_t a;
        smp_t b;
        a = sat16(m + vol_scale(ret, rv));
        b = sat16(vol_scale(a, mv));
        return headroom(b);
    endfunction

endpackage

// File: rtl/mix_voice_sum.sv
module mix_voice_sum
    import stereo_mix_pkg::*;
#(
    parameter int NUM_VOICES = 24
) (
    input  logic [NUM_VOICES*SMP_W-1:0] smp_flat,
    input  logic [NUM_VOICES*SMP_W-1:0] vol_l_flat,
    input  logic [NUM_VOICES*SMP_W-1:0] vol_r_flat,
    input  logic [NUM_VOICES-1:0]       mask,
    output acc_pair_t                   main_o,
    output acc_pair_t                   send_o
);

    acc_t term_l [NUM_VOICES];
    acc_t term_r [NUM_VOICES];

    for (genvar g = 0; g < NUM_VOICES; g++) begin : g_voice
        smp_t s;
        assign s = $signed(smp_flat[g*SMP_W +: SMP_W]);
        assign term_l[g] = vol_scale(s, $signed(vol_l_flat[g*SMP_W +: SMP_W]));
        assign term_r[g] = vol_scale(s, $signed(vol_r_flat[g*SMP_W +: SMP_W]));
    end

    always_comb begin
        main_o = '0;
        send_o = '0;
        for (int i = 0; i < NUM_VOICES; i++) begin
            main_o.l = main_o.l + term_l[i];
            main_o.r = main_o.r + term_r[i];
            if (mask[i]) begin
                send_o.l = send_o.l + term_l[i];
                send_o.r = send_o.r + term_r[i];
            end
        end
    end

endmodule

// File: rtl/mix_ext_in.sv
module mix_ext_in
    import stereo_mix_pkg::*;
(
    input  acc_pair_t main_i,
    input  acc_pair_t send_i,
    input  logic      mix_en,
    input  logic      cd_en,
    input  logic      cd_rvb,
    input  smp_t      cd_l,
    input  smp_t      cd_r,
    input  smp_t      cd_vol_l,
    input  smp_t      cd_vol_r,
    output acc_pair_t main_o,
    output smp_pair_t send_o
);

    acc_pair_t cd_term;
    acc_pair_t send_sum;

    assign cd_term.l = vol_scale(cd_l, cd_vol_l);
    assign cd_term.r = vol_scale(cd_r, cd_vol_r);

    always_comb begin
        main_o   = mix_en ? main_i : '0;
        send_sum = mix_en ? send_i : '0;
        if (cd_en) begin
            main_o.l = main_o.l + cd_term.l;
            main_o.r = main_o.r + cd_term.r;
            if (cd_rvb) begin
                send_sum.l = send_sum.l + cd_term.l;
                send_sum.r = send_sum.r + cd_term.r;
            end
        end
        send_o.l = sat16(send_sum.l);
        send_o.r = sat16(send_sum.r);
    end

endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage
    import stereo_mix_pkg::*;
#(
    parameter int CAP_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_stb,
    input  acc_pair_t        main_i,
    input  smp_pair_t        send_i,
    input  smp_t             ret_l,
    input  smp_t             ret_r,
    input  smp_t             rvb_vol_l,
    input  smp_t             rvb_vol_r,
    input  smp_t             mst_vol_l,
    input  smp_t             mst_vol_r,
    output smp_t             out_l,
    output smp_t             out_r,
    output smp_t             send_l,
    output smp_t             send_r,
    output logic             out_valid,
    output logic [CAP_W-1:0] cap_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_l     <= '0;
            out_r     <= '0;
            send_l    <= '0;
            send_r    <= '0;
            out_valid <= 1'b0;
            cap_addr  <= '0;
        end else begin
            out_valid <= sample_stb;
            if (sample_stb) begin
                out_l    <= final_chan(main_i.l, ret_l, rvb_vol_l, mst_vol_l);
                out_r    <= final_chan(main_i.r, ret_r, rvb_vol_r, mst_vol_r);
                send_l   <= send_i.l;
                send_r   <= send_i.r;
                cap_addr <= cap_addr + 1'b1;
            end
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> ($stable(out_l) && $stable(out_r) && $stable(send_l)
                         && $stable(send_r) && !out_valid));

    p_cap_step_r10: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> (cap_addr == CAP_W'($past(cap_addr) + 1'b1)));

    p_headroom_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_l >= -16'sd24576 && out_l <= 16'sd24575
                       && out_r >= -16'sd24576 && out_r <= 16'sd24575));

endmodule

// File: rtl/stereo_mix_out.sv
module stereo_mix_out
    import stereo_mix_pkg::*;
#(
    parameter int NUM_VOICES = 24,
    parameter int CAP_W      = 9
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sample_stb,
    input  logic [NUM_VOICES*16-1:0]    voice_smp,
    input  logic [NUM_VOICES*16-1:0]    voice_vol_l,
    input  logic [NUM_VOICES*16-1:0]    voice_vol_r,
    input  logic [NUM_VOICES-1:0]       rvb_mask,
    input  logic                        mix_en,
    input  logic                        cd_en,
    input  logic                        cd_rvb,
    input  logic signed [15:0]          cd_l,
    input  logic signed [15:0]          cd_r,
    input  logic signed [15:0]          cd_vol_l,
    input  logic signed [15:0]          cd_vol_r,
    input  logic signed [15:0]          rvb_ret_l,
    input  logic signed [15:0]          rvb_ret_r,
    input  logic signed [15:0]          rvb_vol_l,
    input  logic signed [15:0]          rvb_vol_r,
    input  logic signed [15:0]          mst_vol_l,
    input  logic signed [15:0]          mst_vol_r,
    output logic signed [15:0]          out_l,
    output logic signed [15:0]          out_r,
    output logic                        out_valid,
    output logic signed [15:0]          send_l,
    output logic signed [15:0]          send_r,
    output logic [CAP_W-1:0]            cap_addr
);

    acc_pair_t voice_main;
    acc_pair_t voice_send;
    acc_pair_t mixed_main;
    smp_pair_t mixed_send;

    mix_voice_sum #(.NUM_VOICES(NUM_VOICES)) u_voice_sum (
        .smp_flat   (voice_smp),
        .vol_l_flat (voice_vol_l),
        .vol_r_flat (voice_vol_r),
        .mask       (rvb_mask),
        .main_o     (voice_main),
        .send_o     (voice_send)
    );

    mix_ext_in u_ext_in (
        .main_i   (voice_main),
        .send_i   (voice_send),
        .mix_en   (mix_en),
        .cd_en    (cd_en),
        .cd_rvb   (cd_rvb),
        .cd_l     (cd_l),
        .cd_r     (cd_r),
        .cd_vol_l (cd_vol_l),
        .cd_vol_r (cd_vol_r),
        .main_o   (mixed_main),
        .send_o   (mixed_send)
    );

    mix_out_stage #(.CAP_W(CAP_W)) u_out_stage (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .main_i     (mixed_main),
        .send_i     (mixed_send),
        .ret_l      (rvb_ret_l),
        .ret_r      (rvb_ret_r),
        .rvb_vol_l  (rvb_vol_l),
        .rvb_vol_r  (rvb_vol_r),
        .mst_vol_l  (mst_vol_l),
        .mst_vol_r  (mst_vol_r),
        .out_l      (out_l),
        .out_r      (out_r),
        .send_l     (send_l),
        .send_r     (send_r),
        .out_valid  (out_valid),
        .cap_addr   (cap_addr)
    );

    // silenced voices with no disc feed leave the send at zero
    p_mute_send_r3: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && !mix_en && !cd_en) |=> (send_l == 16'sd0 && send_r == 16'sd0));

endmodule

// File: tb/stereo_mix_out_tb.sv
module stereo_mix_out_tb;

    localparam int NV    = 24;
    localparam int CAP_W = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst;
    logic                  sample_stb;
    logic [NV*16-1:0]      voice_smp, voice_vol_l, voice_vol_r;
    logic [NV-1:0]         rvb_mask;
    logic                  mix_en, cd_en, cd_rvb;
    logic signed [15:0]    cd_l, cd_r, cd_vol_l, cd_vol_r;
    logic signed [15:0]    rvb_ret_l, rvb_ret_r, rvb_vol_l, rvb_vol_r;
    logic signed [15:0]    mst_vol_l, mst_vol_r;
    logic signed [15:0]    out_l, out_r, send_l, send_r;
    logic                  out_valid;
    logic [CAP_W-1:0]      cap_addr;

    stereo_mix_out #(.NUM_VOICES(NV), .CAP_W(CAP_W)) u_dut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb),
        .voice_smp(voice_smp), .voice_vol_l(voice_vol_l), .voice_vol_r(voice_vol_r),
        .rvb_mask(rvb_mask), .mix_en(mix_en), .cd_en(cd_en), .cd_rvb(cd_rvb),
        .cd_l(cd_l), .cd_r(cd_r), .cd_vol_l(cd_vol_l), .cd_vol_r(cd_vol_r),
        .rvb_ret_l(rvb_ret_l), .rvb_ret_r(rvb_ret_r),
        .rvb_vol_l(rvb_vol_l), .rvb_vol_r(rvb_vol_r),
        .mst_vol_l(mst_vol_l), .mst_vol_r(mst_vol_r),
        .out_l(out_l), .out_r(out_r), .out_valid(out_valid),
        .send_l(send_l), .send_r(send_r), .cap_addr(cap_addr)
    );

    int n_run  = 0;
    int n_fail = 0;
    int cap_model = 0;
    logic [31:0] seed = 32'h1234_5678;

    // stimulus state
    int vs [NV];
    int vl [NV];
    int vr [NV];
    logic [NV-1:0] msk;
    int m_cdl, m_cdr, m_cdvl, m_cdvr, m_retl, m_retr, m_rvl, m_rvr, m_mvl, m_mvr;
    logic m_mix, m_cd, m_cdrv;

    typedef struct {
        int    ol;
        int    orr;
        int    sl;
        int    sr;
        int    cap;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(string tag, string what, int act, int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    function automatic longint scl(longint a, longint b);
        return (a * b) >>> 15;
    endfunction

    function automatic longint sat(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint fin(longint m, longint ret, longint rv, longint mv);
        longint a, b;
        a = sat(m + scl(ret, rv));
        b = sat(scl(a, mv));
        return (b * 3 + 2) >>> 2;
    endfunction

    task automatic clear_stim();
        for (int v = 0; v < NV; v++) begin
            vs[v] = 0; vl[v] = 0; vr[v] = 0;
        end
        msk = '0;
        m_cdl = 0; m_cdr = 0; m_cdvl = 0; m_cdvr = 0;
        m_retl = 0; m_retr = 0; m_rvl = 0; m_rvr = 0;
        m_mvl = 32767; m_mvr = 32767;
        m_mix = 1'b1; m_cd = 1'b0; m_cdrv = 1'b0;
    endtask

    task automatic drive(string tag);
        longint ml, mr, sl, sr, cl, cr;
        exp_t e;
        ml = 0; mr = 0; sl = 0; sr = 0;
        for (int v = 0; v < NV; v++) begin
            ml += scl(vs[v], vl[v]);
            mr += scl(vs[v], vr[v]);
            if (msk[v]) begin
                sl += scl(vs[v], vl[v]);
                sr += scl(vs[v], vr[v]);
            end
        end
        if (!m_mix) begin
            ml = 0; mr = 0; sl = 0; sr = 0;
        end
        cl = scl(m_cdl, m_cdvl);
        cr = scl(m_cdr, m_cdvr);
        if (m_cd) begin
            ml += cl; mr += cr;
            if (m_cdrv) begin
                sl += cl; sr += cr;
            end
        end
        cap_model = (cap_model + 1) % 512;
        e.ol  = int'(fin(ml, m_retl, m_rvl, m_mvl));
        e.orr = int'(fin(mr, m_retr, m_rvr, m_mvr));
        e.sl  = int'(sat(sl));
        e.sr  = int'(sat(sr));
        e.cap = cap_model;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            voice_smp[v*16 +: 16]   = 16'(vs[v]);
            voice_vol_l[v*16 +: 16] = 16'(vl[v]);
            voice_vol_r[v*16 +: 16] = 16'(vr[v]);
        end
        rvb_mask = msk;
        mix_en = m_mix; cd_en = m_cd; cd_rvb = m_cdrv;
        cd_l = 16'(m_cdl); cd_r = 16'(m_cdr); cd_vol_l = 16'(m_cdvl); cd_vol_r = 16'(m_cdvr);
        rvb_ret_l = 16'(m_retl); rvb_ret_r = 16'(m_retr);
        rvb_vol_l = 16'(m_rvl); rvb_vol_r = 16'(m_rvr);
        mst_vol_l = 16'(m_mvl); mst_vol_r = 16'(m_mvr);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    // monitor: pops expected items when a result appears
    logic idle_chk = 1'b0;
    int last_l, last_r;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R11", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, "out_l", int'(out_l), e.ol);
                    check(e.tag, "out_r", int'(out_r), e.orr);
                    check(e.tag, "send_l", int'(send_l), e.sl);
                    check(e.tag, "send_r", int'(send_r), e.sr);
                    check("R10", "cap_addr", int'(cap_addr), e.cap);
                end
                last_l = int'(out_l);
                last_r = int'(out_r);
                idle_chk = 1'b1;
            end else if (!rst && idle_chk) begin
                check("R11", "out_l hold", int'(out_l), last_l);
                check("R11", "out_r hold", int'(out_r), last_r);
                idle_chk = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sample_stb = 1'b0;
        voice_smp = '0; voice_vol_l = '0; voice_vol_r = '0; rvb_mask = '0;
        mix_en = 1'b0; cd_en = 1'b0; cd_rvb = 1'b0;
        cd_l = '0; cd_r = '0; cd_vol_l = '0; cd_vol_r = '0;
        rvb_ret_l = '0; rvb_ret_r = '0; rvb_vol_l = '0; rvb_vol_r = '0;
        mst_vol_l = '0; mst_vol_r = '0;
        repeat (4) @(negedge clk);
        // R11 / R10 reset state
        check("R11", "reset out_l", int'(out_l), 0);
        check("R11", "reset out_valid", int'(out_valid), 0);
        check("R6", "reset send_l", int'(send_l), 0);
        check("R10", "reset cap_addr", int'(cap_addr), 0);
        rst = 1'b0;

        // R1: single voice, unmasked
        clear_stim();
        vs[0] = 12345; vl[0] = 16384; vr[0] = -8192;
        drive("R1");
        vs[5] = -20001; vl[5] = 30000; vr[5] = 1;
        drive("R1");

        // R2: mask patterns with varied samples
        for (int it = 0; it < 6; it++) begin
            clear_stim();
            for (int v = 0; v < NV; v++) begin
                vs[v] = rnd16() / 4; vl[v] = rnd16(); vr[v] = rnd16();
            end
            msk = NV'(seed);
            drive("R2");
        end

        // R6/R7: everything full scale positive, saturates send and main
        clear_stim();
        for (int v = 0; v < NV; v++) begin
            vs[v] = 30000; vl[v] = 32767; vr[v] = 32767;
        end
        msk = '1;
        drive("R6");
        m_retl = 32767; m_rvl = 32767; m_retr = -32768; m_rvr = 32767;
        drive("R7");

        // R8/R9: negative main times negative master saturates to +max
        clear_stim();
        for (int v = 0; v < NV; v++) begin
            vs[v] = -30000; vl[v] = 32767; vr[v] = 32767;
        end
        m_mvl = -32768; m_mvr = 32767;
        drive("R8");
        clear_stim();
        vs[0] = -1; vl[0] = 32767; vr[0] = 16384;
        drive("R9");

        // R3: mute voices, with and without disc feed
        clear_stim();
        for (int v = 0; v < NV; v++) begin
            vs[v] = 1000 + v; vl[v] = 20000; vr[v] = -20000;
        end
        msk = '1; m_mix = 1'b0;
        drive("R3");
        m_cd = 1'b1; m_cdrv = 1'b1; m_cdl = 9000; m_cdvl = 32767; m_cdr = -9000; m_cdvr = 16384;
        drive("R3");

        // R4/R5: the four disc enable combinations
        for (int c = 0; c < 4; c++) begin
            clear_stim();
            vs[2] = 4000; vl[2] = 32767; vr[2] = 32767; msk[2] = 1'b1;
            m_cdl = -12000; m_cdvl = 25000; m_cdr = 17000; m_cdvr = -30000;
            m_cd = c[0]; m_cdrv = c[1];
            drive(c[1] ? "R5" : "R4");
        end

        // R7: reverb return mid-range
        clear_stim();
        vs[1] = 5000; vl[1] = 32767; vr[1] = 32767;
        m_retl = 10000; m_rvl = 16384; m_retr = -10000; m_rvr = 8192;
        drive("R7");

        // R10: run past the address wrap
        clear_stim();
        for (int k = 0; k < 520; k++) begin
            vs[0] = k; vl[0] = 32767; vr[0] = 32767;
            drive("R10");
        end

        repeat (6) @(negedge clk);
        check("R11", "pending results", sb_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule